// File: doc/BRIEF.md
# Cascadable Bidirectional Line Sampler

This block gathers one display line of gray-level codes for a column driver. Each rising clock edge carries one pixel: three 6-bit sub-pixel codes on three buses. A line is 80 clocks long, and the 80 slots of the block fill a register that feeds 240 channels. Filling begins when a start pulse is seen on the start pin that is currently the input. From then on, one slot is written on every edge. A direction control picks which end of the channel row fills first. The same control swaps the roles of the two start pins, so one pin receives the start pulse and the other passes it on.

When the last slot has been written, the block sends a one-clock start pulse out of the other pin. A second block wired to that pin then takes the following 80 pixels of the same stream. An invert control, sampled on every edge, complements the codes as they are stored. A rising edge on the strobe input stops any fill in progress and leaves the stored codes as they are. The block then waits for a fresh start pulse.

Top module: `line_sampler`

## Requirements
- R1: After synchronous reset, every bit of `line_q` is 0 and both start outputs are low.
- R2: The edge at which the selected start input is high writes that edge's pixel into the first slot. Each following edge writes the next slot, for 80 slots in total.
- R3: With `dir_up` = 1, `lo_start_in` is the start input and `hi_start_out` carries the start output (`hi_start_oe` = 1, `lo_start_oe` = 0). Logical slot j lands in physical slot j.
- R4: With `dir_up` = 0, `hi_start_in` is the start input and `lo_start_out` carries the start output (`lo_start_oe` = 1, `hi_start_oe` = 0). Logical slot j lands in physical slot 79 − j.
- R5: Physical slot s holds channels 3s, 3s+1 and 3s+2, taken from `sub_a`, `sub_b` and `sub_c` respectively. Channel ch occupies `line_q[ch*6 +: 6]`, with bit 0 as the LSB.
- R6: When `inv_en` is high at a capturing edge, the three codes are stored bitwise complemented. When it is low, they are stored unchanged.
- R7: The driven start output is high for exactly one clock. It rises at the edge that writes the 80th slot, so a chained block captures its first pixel at the next edge.
- R8: Once all 80 slots are written, further edges change no slot until a new start pulse arrives.
- R9: A rising edge on `strobe` (low at the previous edge, high at this one) stops the fill. No slot is written at that edge or after it, until a new start pulse arrives. The start pulse for that line is never sent, and slots already written keep their codes.
- R10: While a pin serves as the start output, a high level on its input is ignored.
- R11: Two blocks chained through their start pins take pixels 1–80 and 81–160 of one stream, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_up | input | 1 | 1: fill from channel 0 upward; 0: fill from the top channel down |
| inv_en | input | 1 | Complement incoming codes at this edge |
| strobe | input | 1 | Line strobe; its rising edge clears the fill sequence |
| sub_a | input | 6 | First sub-pixel code of the pixel |
| sub_b | input | 6 | Second sub-pixel code of the pixel |
| sub_c | input | 6 | Third sub-pixel code of the pixel |
| lo_start_in | input | 1 | Input side of the start pin at the channel-0 end |
| lo_start_out | output | 1 | Output side of the start pin at the channel-0 end |
| lo_start_oe | output | 1 | Drive enable of the channel-0-end start pin |
| hi_start_in | input | 1 | Input side of the start pin at the top-channel end |
| hi_start_out | output | 1 | Output side of the start pin at the top-channel end |
| hi_start_oe | output | 1 | Drive enable of the top-channel-end start pin |
| line_q | output | 1440 | 240 stored 6-bit codes, channel ch at bits ch*6+5..ch*6 |

## Verification
The assertions check the following on every cycle:
- Exactly one start pin is driven.
- At most one slot is written per edge.
- The forwarded pulse lasts a single cycle and follows a write of the last slot.
- A strobe edge is never followed by a forwarded pulse.
- A finished line is not overwritten without a new start.

Some behaviour only the bench scenarios can show, because it depends on values across a whole line:
- The mapping of pixels onto channels in each direction.
- Complementing under a random per-edge invert pattern.
- The hand-over of pixels 81–160 to a chained block.
- The partial line left behind by a strobe in mid-fill.

// File: rtl/lsamp_pkg.sv
// Shared sizing for the line sampler.
// Assumes: three sub-pixels per clock, one slot per clock, 80 slots per line.
package lsamp_pkg;
    parameter int SUB_W     = 6;
    parameter int SUB_N     = 3;
    parameter int SLOT_N    = 80;
    localparam int PIX_W    = SUB_W * SUB_N;
    localparam int CHAN_N   = SLOT_N * SUB_N;
    localparam int LINE_W   = CHAN_N * SUB_W;
    localparam int IDX_W    = (SLOT_N > 1) ? $clog2(SLOT_N) : 1;
endpackage

// File: rtl/lsamp_inv.sv
// Conditional complement of one pixel's sub-pixel codes.
// Assumes: inv is sampled together with the data at the capturing edge.
module lsamp_inv #(
    parameter int SUB_W = lsamp_pkg::SUB_W,
    parameter int SUB_N = lsamp_pkg::SUB_N
) (
    input  logic [SUB_W*SUB_N-1:0] raw,
    input  logic                   inv,
    output logic [SUB_W*SUB_N-1:0] cooked
);
    // One XOR lane per sub-pixel code.
    for (genvar k = 0; k < SUB_N; k++) begin : g_lane
        assign cooked[k*SUB_W +: SUB_W] = raw[k*SUB_W +: SUB_W] ^ {SUB_W{inv}};
    end
endmodule

// File: rtl/lsamp_seq.sv
// Fill sequencer: tracks the logical slot index, issues a write enable per
// edge and emits a one-clock hand-over pulse after the last slot.
// Assumes: start_in is already the direction-selected start input.
module lsamp_seq #(
    parameter int SLOT_N = lsamp_pkg::SLOT_N,
    localparam int IDX_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_in,
    input  logic             strobe,
    output logic             cap_en,
    output logic [IDX_W-1:0] cur_idx,
    output logic             done_pulse
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOT_N - 1);

    logic             busy;
    logic [IDX_W-1:0] nxt_idx;
    logic             strobe_q;
    logic             strobe_rise;
    logic             at_last;

    assign strobe_rise = strobe & ~strobe_q;
    assign cap_en      = ~strobe_rise & (start_in | busy);
    assign cur_idx     = start_in ? '0 : nxt_idx;
    assign at_last     = (cur_idx == LAST);

    // Advance the slot index, finish the line, or abort on a strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            nxt_idx    <= '0;
            strobe_q   <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            strobe_q <= strobe;
            if (strobe_rise) begin
                busy       <= 1'b0;
                nxt_idx    <= '0;
                done_pulse <= 1'b0;
            end else if (cap_en) begin
                if (at_last) begin
                    busy       <= 1'b0;
                    nxt_idx    <= '0;
                    done_pulse <= 1'b1;
                end else begin
                    busy       <= 1'b1;
                    nxt_idx    <= cur_idx + 1'b1;
                    done_pulse <= 1'b0;
                end
            end else begin
                done_pulse <= 1'b0;
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R7
    AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> ($past(cap_en) && $past(cur_idx) == LAST)); // R7
    AST_STROBE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !strobe_q) |=> !done_pulse); // R9
    AST_NO_WRITE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && !start_in) |-> !cap_en); // R8
endmodule

// File: rtl/lsamp_slots.sv
// Slot storage: maps the logical index to a physical slot according to the
// fill direction and writes the three codes of the pixel into that slot.
// Assumes: at most one write per edge; codes are already conditioned.
module lsamp_slots #(
    parameter int SUB_W  = lsamp_pkg::SUB_W,
    parameter int SUB_N  = lsamp_pkg::SUB_N,
    parameter int SLOT_N = lsamp_pkg::SLOT_N,
    localparam int IDX_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1,
    localparam int PIX_W = SUB_W * SUB_N,
    localparam int LINE_W = PIX_W * SLOT_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_up,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [PIX_W-1:0]  wdata,
    output logic [LINE_W-1:0] line_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOT_N - 1);

    logic [IDX_W-1:0]  phys_idx;
    logic [SLOT_N-1:0] we;

    // Mirror the index when filling downward.
    always_comb phys_idx = dir_up ? cur_idx : (LAST - cur_idx);

    for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
        assign we[s] = cap_en && (phys_idx == IDX_W'(s));
        // Hold or overwrite the three codes of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)     line_q[s*PIX_W +: PIX_W] <= '0;
            else if (we[s]) line_q[s*PIX_W +: PIX_W] <= wdata;
        end
    end

    AST_ONEHOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we)); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(line_q)); // R8
endmodule

// File: rtl/line_sampler.sv
// Cascadable line sampler top: routes the two start pins by direction,
// conditions the incoming pixel and stores it into the addressed slot.
// Assumes: each start pin is modelled as in/out/output-enable; the pad
// combines them outside this block.
module line_sampler #(
    parameter int SUB_W  = lsamp_pkg::SUB_W,
    parameter int SUB_N  = lsamp_pkg::SUB_N,
    parameter int SLOT_N = lsamp_pkg::SLOT_N,
    localparam int IDX_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1,
    localparam int PIX_W = SUB_W * SUB_N,
    localparam int LINE_W = PIX_W * SLOT_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_up,
    input  logic              inv_en,
    input  logic              strobe,
    input  logic [SUB_W-1:0]  sub_a,
    input  logic [SUB_W-1:0]  sub_b,
    input  logic [SUB_W-1:0]  sub_c,
    input  logic              lo_start_in,
    output logic              lo_start_out,
    output logic              lo_start_oe,
    input  logic              hi_start_in,
    output logic              hi_start_out,
    output logic              hi_start_oe,
    output logic [LINE_W-1:0] line_q
);
    logic             start_sel;
    logic             cap_en;
    logic [IDX_W-1:0] cur_idx;
    logic             done_pulse;
    logic [PIX_W-1:0] raw_pix;
    logic [PIX_W-1:0] cond_pix;

    // Pick the start input and steer the hand-over pulse by direction.
    always_comb begin
        start_sel    = dir_up ? lo_start_in : hi_start_in;
        hi_start_oe  = dir_up;
        lo_start_oe  = ~dir_up;
        hi_start_out = dir_up & done_pulse;
        lo_start_out = ~dir_up & done_pulse;
    end

    // Pack the buses; sub_a occupies the lowest field.
    always_comb raw_pix = {sub_c, sub_b, sub_a};

    lsamp_inv #(.SUB_W(SUB_W), .SUB_N(SUB_N)) u_inv (
        .raw    (raw_pix),
        .inv    (inv_en),
        .cooked (cond_pix)
    );

    lsamp_seq #(.SLOT_N(SLOT_N)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_in   (start_sel),
        .strobe     (strobe),
        .cap_en     (cap_en),
        .cur_idx    (cur_idx),
        .done_pulse (done_pulse)
    );

    lsamp_slots #(.SUB_W(SUB_W), .SUB_N(SUB_N), .SLOT_N(SLOT_N)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_up  (dir_up),
        .cap_en  (cap_en),
        .cur_idx (cur_idx),
        .wdata   (cond_pix),
        .line_q  (line_q)
    );

    AST_ONE_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lo_start_oe, hi_start_oe}) == 1); // R3
    AST_OUT_ONLY_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_start_out && !lo_start_oe) && !(hi_start_out && !hi_start_oe)); // R4
endmodule

// File: tb/line_sampler_bench.sv
`timescale 1ns/1ps
module line_sampler_bench;
    localparam int SLOTS = 80;
    localparam int CH    = 240;
    localparam int LW    = CH * 6;
    localparam int EDGES = 162;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_up = 1'b1, inv_en = 1'b0, strobe = 1'b0;
    logic [5:0] sub_a = '0, sub_b = '0, sub_c = '0;
    logic lo_in = 1'b0, hi_in = 1'b0;
    logic c1_lo_out, c1_lo_oe, c1_hi_out, c1_hi_oe;
    logic c2_lo_out, c2_lo_oe, c2_hi_out, c2_hi_oe;
    logic c2_lo_in, c2_hi_in;
    logic [LW-1:0] c1_line, c2_line;

    int tests = 0, fails = 0;
    logic [17:0] pix [EDGES];
    logic        invf [EDGES];
    logic [5:0]  exp1 [CH];
    logic [5:0]  exp2 [CH];

    always #2.5 clk = ~clk;

    // Chip 2's start pins listen to chip 1's driven pins.
    assign c2_hi_in = c1_lo_out & c1_lo_oe;
    assign c2_lo_in = c1_hi_out & c1_hi_oe;

    line_sampler u_line_sampler (
        .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .inv_en(inv_en), .strobe(strobe),
        .sub_a(sub_a), .sub_b(sub_b), .sub_c(sub_c),
        .lo_start_in(lo_in), .lo_start_out(c1_lo_out), .lo_start_oe(c1_lo_oe),
        .hi_start_in(hi_in), .hi_start_out(c1_hi_out), .hi_start_oe(c1_hi_oe),
        .line_q(c1_line));

    line_sampler u_line_sampler_nxt (
        .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .inv_en(inv_en), .strobe(strobe),
        .sub_a(sub_a), .sub_b(sub_b), .sub_c(sub_c),
        .lo_start_in(c2_lo_in), .lo_start_out(c2_lo_out), .lo_start_oe(c2_lo_oe),
        .hi_start_in(c2_hi_in), .hi_start_out(c2_hi_out), .hi_start_oe(c2_hi_oe),
        .line_q(c2_line));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Expected code of one pixel's sub-pixel k after optional complement.
    function automatic logic [5:0] code_of(input logic [17:0] p, input int k, input logic inv);
        code_of = p[k*6 +: 6] ^ {6{inv}};
    endfunction

    // Model update for a captured logical slot (R3/R4/R5/R6).
    task automatic model_write(input int chip, input int j, input logic up, input int e);
        int phys = up ? j : (SLOTS - 1 - j);
        for (int k = 0; k < 3; k++) begin
            if (chip == 1) exp1[3*phys+k] = code_of(pix[e], k, invf[e]);
            else           exp2[3*phys+k] = code_of(pix[e], k, invf[e]);
        end
    endtask

    task automatic check_line(input int chip, input string req);
        int bad = -1;
        logic [5:0] act, ex;
        for (int ch = 0; ch < CH; ch++) begin
            act = (chip == 1) ? c1_line[ch*6 +: 6] : c2_line[ch*6 +: 6];
            ex  = (chip == 1) ? exp1[ch] : exp2[ch];
            if (act != ex && bad < 0) bad = ch;
        end
        if (bad < 0) check(1'b1, req, "line", 0, 0);
        else begin
            act = (chip == 1) ? c1_line[bad*6 +: 6] : c2_line[bad*6 +: 6];
            ex  = (chip == 1) ? exp1[bad] : exp2[bad];
            check(1'b0, req, $sformatf("chip%0d channel %0d", chip, bad), act, ex);
        end
    endtask

    // Run EDGES clock edges. inv_mode: 0 off, 1 on, 2 random.
    // stb_at < 0 means no strobe; junk drives the output-side pin high.
    task automatic run_line(input logic up, input int inv_mode, input bit do_start,
                            input int stb_at, input bit junk, input string req);
        int p1_cnt = 0, p1_at = -1, p2_cnt = 0, p2_at = -1;
        bit c1_done = do_start && (stb_at < 0 || stb_at > SLOTS - 1);
        bit c2_done = c1_done && (stb_at < 0 || stb_at > 2*SLOTS - 1);
        for (int e = 0; e < EDGES; e++) begin
            pix[e]  = 18'($urandom);
            invf[e] = (inv_mode == 2) ? 1'($urandom) : (inv_mode == 1);
        end
        for (int e = 0; e <= EDGES; e++) begin
            @(negedge clk);
            if (e > 0) begin
                // Outputs here reflect edge e-1.
                if (up ? c1_hi_out : c1_lo_out) begin p1_cnt++; if (p1_at < 0) p1_at = e - 1; end
                if (up ? c2_hi_out : c2_lo_out) begin p2_cnt++; if (p2_at < 0) p2_at = e - 1; end
            end
            if (e < EDGES) begin
                dir_up = up;
                {sub_c, sub_b, sub_a} = pix[e];
                inv_en = invf[e];
                strobe = (e == stb_at);
                lo_in  = up ? (do_start && e == 0) : junk;
                hi_in  = up ? junk : (do_start && e == 0);
                if (do_start && e < SLOTS && (stb_at < 0 || e < stb_at))
                    model_write(1, e, up, e);
                if (c1_done && e >= SLOTS && e < 2*SLOTS && (stb_at < 0 || e < stb_at))
                    model_write(2, e - SLOTS, up, e);
            end
        end
        strobe = 1'b0; lo_in = 1'b0; hi_in = 1'b0;
        check_line(1, req);
        check_line(2, req);
        // R7: one-cycle hand-over pulse at the edge filling the 80th slot.
        check(p1_cnt == (c1_done ? 1 : 0), "R7", "chip1 pulse count", p1_cnt, c1_done ? 1 : 0);
        if (c1_done) check(p1_at == SLOTS - 1, "R7", "chip1 pulse edge", p1_at, SLOTS - 1);
        check(p2_cnt == (c2_done ? 1 : 0), "R11", "chip2 pulse count", p2_cnt, c2_done ? 1 : 0);
        if (c2_done) check(p2_at == 2*SLOTS - 1, "R11", "chip2 pulse edge", p2_at, 2*SLOTS - 1);
    endtask

    initial begin
        void'($urandom(32'h1CE5_0A11));
        for (int ch = 0; ch < CH; ch++) begin exp1[ch] = '0; exp2[ch] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check_line(1, "R1");
        check(!c1_lo_out && !c1_hi_out, "R1", "start outputs", {c1_lo_out, c1_hi_out}, 0);
        // R3: pin roles for upward fill.
        dir_up = 1'b1; #0.1;
        check(c1_hi_oe && !c1_lo_oe, "R3", "oe up", {c1_lo_oe, c1_hi_oe}, 1);
        // R2 R3 R5 R6 R11: upward line with random inversion.
        run_line(1'b1, 2, 1'b1, -1, 1'b0, "R2_R3_R5_R11");
        // R8: more edges without a start leave both lines unchanged.
        run_line(1'b1, 2, 1'b0, -1, 1'b0, "R8");
        // R10: output-side pin held high is ignored.
        run_line(1'b1, 0, 1'b0, -1, 1'b1, "R10");
        // R4: pin roles and mirrored fill downward.
        dir_up = 1'b0; #0.1;
        check(c1_lo_oe && !c1_hi_oe, "R4", "oe down", {c1_lo_oe, c1_hi_oe}, 2);
        run_line(1'b0, 2, 1'b1, -1, 1'b0, "R4_R11");
        // R6: every code complemented.
        run_line(1'b0, 1, 1'b1, -1, 1'b0, "R6");
        run_line(1'b0, 1, 1'b0, -1, 1'b1, "R10");
        // R9: strobe edge in mid-fill stops chip 1, chip 2 never starts.
        run_line(1'b1, 0, 1'b1, 30, 1'b0, "R9");
        run_line(1'b0, 2, 1'b1, 79, 1'b0, "R9");
        // R9: strobe during chip 2's portion stops it there.
        run_line(1'b1, 2, 1'b1, 120, 1'b0, "R9");
        // Random lines in both directions.
        for (int i = 0; i < 4; i++)
            run_line(1'($urandom), 2, 1'b1, -1, 1'b0, "R2_R11");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule